// File: doc/BRIEF.md
# Programmable IO Address Window Decoder

The block maps a 48-bit physical address onto a small target identifier through a bank of programmable windows. Each window holds an inclusive lower bound, an inclusive upper bound and a target value. Both bounds have a granularity of 1 MB, and the enable flag sits in the lowest bit of the lower-bound register. A global register holds the fallback target. That target applies to any address that no enabled window covers. When enabled windows overlap, the one with the lowest index takes the address.

Software programs the windows through a flat register port with address, write enable, write data and combinational read data. Every register stores all 32 bits exactly as written. Software can therefore clear an enable bit with a read-modify-write, and it can save and restore the whole set. By convention window 0 belongs to the boot path and general windows start at index 1. Temporary windows are taken from the highest index downward. The hardware itself treats all windows alike.

The decode side takes an address with a valid strobe. One clock later it returns the chosen target, a hit flag and the index of the matching window.

Top module: `io_win_decoder`

## Requirements
- R1: For window w, the lower-bound register is at byte offset 16*w+0x0, the upper-bound register at 16*w+0x8 and the target register at 16*w+0xC. Each reads back all 32 bits exactly as last written.
- R2: The global register sits at offset 16*NUM_WIN and reads back all 32 bits as written. Any other offset reads 0, and a write to it changes no register.
- R3: After reset every register reads 0. This leaves every window disabled and the fallback target at 0, and decode outputs are 0.
- R4: A window whose lower-bound register has bit 0 clear never matches.
- R5: An enabled window matches when address bits [47:20] are at least its lower-bound bits [31:4] and at most its upper-bound bits [31:4]. Both bounds are inclusive, and bound-register bits [3:1] are ignored.
- R6: If several enabled windows match, the lowest-numbered one is reported and supplies the target.
- R7: If no enabled window matches, hit is 0, the window index is 0 and the target is bits [3:0] of the global register.
- R8: Decode outputs are registered. They reflect the address sampled on the clock edge where the valid input is high, and they appear together with an output valid on that edge. When the valid input is low they hold their values and the output valid drops.
- R9: On a hit the target is bits [3:0] of the matching window's target register. The upper bits are ignored.
- R10: Address bits [19:0] do not affect the decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | $clog2(NUM_WIN)+5 | Register byte offset |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_addr_i | input | ADDR_W | Physical address to decode |
| dec_valid_o | output | 1 | Decode result valid |
| dec_hit_o | output | 1 | An enabled window matched |
| dec_win_o | output | $clog2(NUM_WIN) | Index of the matching window |
| dec_target_o | output | TGT_W | Selected target |

## Verification
The bench builds the decoder with four windows and keeps the 48-bit address. With four windows the register space is small enough to walk every mapped and unmapped offset. Each decode sweep runs over the 32 lowest 1 MB fields and the topmost fields of the address range, with the low 20 bits scrambled on every step. Those sweeps reach every bound edge, overlap, disabled window and fallback case of the programmed layouts. They also cover the top-of-range field and an enable cleared by read-modify-write.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int REG_W    = 32;
  localparam int GRAN_SH  = 20;
  localparam logic [3:0] OFS_LO  = 4'h0;
  localparam logic [3:0] OFS_HI  = 4'h8;
  localparam logic [3:0] OFS_TGT = 4'hC;
  localparam int EN_BIT   = 0;
  localparam int FLD_LSB  = 4;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
  import io_win_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int REG_AW  = $clog2(NUM_WIN) + 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [REG_AW-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               rdata_o,
  output logic [NUM_WIN-1:0][REG_W-1:0]  lo_o,
  output logic [NUM_WIN-1:0][REG_W-1:0]  hi_o,
  output logic [NUM_WIN-1:0][REG_W-1:0]  tgt_o,
  output logic [REG_W-1:0]               glob_o
);
  localparam int IDX_W = REG_AW - 4;
  localparam int SEL_W = IDX_W - 1;

  logic [IDX_W-1:0] idx;
  logic [3:0]       sub;
  logic [SEL_W-1:0] sel;

  assign idx = addr_i[REG_AW-1:4];
  assign sub = addr_i[3:0];
  assign sel = idx[SEL_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wsel;
    assign wsel = we_i && (idx == IDX_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[w]  <= '0;
        hi_o[w]  <= '0;
        tgt_o[w] <= '0;
      end else if (wsel) begin
        case (sub)
          OFS_LO:  lo_o[w]  <= wdata_i;
          OFS_HI:  hi_o[w]  <= wdata_i;
          OFS_TGT: tgt_o[w] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glob_o <= '0;
    else if (we_i && idx == IDX_W'(NUM_WIN) && sub == 4'h0) glob_o <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (idx < IDX_W'(NUM_WIN)) begin
      case (sub)
        OFS_LO:  rdata_o = lo_o[sel];
        OFS_HI:  rdata_o = hi_o[sel];
        OFS_TGT: rdata_o = tgt_o[sel];
        default: rdata_o = '0;
      endcase
    end else if (idx == IDX_W'(NUM_WIN) && sub == 4'h0) begin
      rdata_o = glob_o;
    end
  end
endmodule

// File: rtl/io_win_match.sv
module io_win_match #(
  parameter int NUM_WIN = 8,
  parameter int FLD_W   = 28
) (
  input  logic [NUM_WIN-1:0]            en_i,
  input  logic [NUM_WIN-1:0][FLD_W-1:0] lo_i,
  input  logic [NUM_WIN-1:0][FLD_W-1:0] hi_i,
  input  logic [FLD_W-1:0]              fld_i,
  output logic [NUM_WIN-1:0]            hit_vec_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic ge_lo, le_hi;
    assign ge_lo = (fld_i >= lo_i[w]);
    assign le_hi = (fld_i <= hi_i[w]);
    assign hit_vec_o[w] = en_i[w] && ge_lo && le_hi;
  end
endmodule

// File: rtl/io_win_pick.sv
module io_win_pick #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hit_vec_i,
  output logic               any_o,
  output logic [WIN_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) idx_o = WIN_W'(i);
    end
  end
  assign any_o = |hit_vec_i;
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import io_win_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 48,
  parameter int TGT_W   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(NUM_WIN)+4:0]   reg_addr_i,
  input  logic                         reg_we_i,
  input  logic [31:0]                  reg_wdata_i,
  output logic [31:0]                  reg_rdata_o,
  input  logic                         dec_valid_i,
  input  logic [ADDR_W-1:0]            dec_addr_i,
  output logic                         dec_valid_o,
  output logic                         dec_hit_o,
  output logic [$clog2(NUM_WIN)-1:0]   dec_win_o,
  output logic [TGT_W-1:0]             dec_target_o
);
  localparam int REG_AW = $clog2(NUM_WIN) + 5;
  localparam int WIN_W  = $clog2(NUM_WIN);
  localparam int FLD_W  = ADDR_W - GRAN_SH;

  logic [NUM_WIN-1:0][REG_W-1:0] lo_q, hi_q, tgt_q;
  logic [REG_W-1:0]              glob_q;
  logic [NUM_WIN-1:0][FLD_W-1:0] lo_fld, hi_fld;
  logic [NUM_WIN-1:0]            en_vec, hit_vec;
  logic                          any_hit;
  logic [WIN_W-1:0]              win_idx;
  logic [TGT_W-1:0]              tgt_sel;

  io_win_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .lo_o    (lo_q),
    .hi_o    (hi_q),
    .tgt_o   (tgt_q),
    .glob_o  (glob_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_fld
    assign en_vec[w] = lo_q[w][EN_BIT];
    assign lo_fld[w] = lo_q[w][FLD_LSB+FLD_W-1:FLD_LSB];
    assign hi_fld[w] = hi_q[w][FLD_LSB+FLD_W-1:FLD_LSB];
  end

  io_win_match #(.NUM_WIN(NUM_WIN), .FLD_W(FLD_W)) u_match (
    .en_i      (en_vec),
    .lo_i      (lo_fld),
    .hi_i      (hi_fld),
    .fld_i     (dec_addr_i[ADDR_W-1:GRAN_SH]),
    .hit_vec_o (hit_vec)
  );

  io_win_pick #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_pick (
    .hit_vec_i (hit_vec),
    .any_o     (any_hit),
    .idx_o     (win_idx)
  );

  assign tgt_sel = any_hit ? tgt_q[win_idx][TGT_W-1:0] : glob_q[TGT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      dec_hit_o    <= 1'b0;
      dec_win_o    <= '0;
      dec_target_o <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_hit_o    <= any_hit;
        dec_win_o    <= win_idx;
        dec_target_o <= tgt_sel;
      end
    end
  end
endmodule

// File: rtl/io_win_decoder_chk.sv
module io_win_decoder_chk #(
  parameter int NUM_WIN = 8,
  parameter int TGT_W   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       dec_valid_i,
  input logic                       dec_valid_o,
  input logic                       dec_hit_o,
  input logic [$clog2(NUM_WIN)-1:0] dec_win_o,
  input logic [TGT_W-1:0]           dec_target_o,
  input logic [NUM_WIN-1:0]         hit_vec,
  input logic [NUM_WIN-1:0]         en_vec
);
  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  // R8
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !dec_valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> ($stable(dec_hit_o) && $stable(dec_win_o) && $stable(dec_target_o)));
  // R7
  miss_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_hit_o |-> dec_win_o == '0);
  // R4
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && en_vec == '0) |=> !dec_hit_o);
  // R6
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && hit_vec[0]) |=> (dec_hit_o && dec_win_o == '0));
  // R5
  hit_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_hit_o == $past(|hit_vec));
endmodule

bind io_win_decoder io_win_decoder_chk #(.NUM_WIN(NUM_WIN), .TGT_W(TGT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dec_valid_i  (dec_valid_i),
  .dec_valid_o  (dec_valid_o),
  .dec_hit_o    (dec_hit_o),
  .dec_win_o    (dec_win_o),
  .dec_target_o (dec_target_o),
  .hit_vec      (hit_vec),
  .en_vec       (en_vec)
);

// File: tb/io_win_decoder_bench.sv
module io_win_decoder_bench;
  localparam int NW  = 4;
  localparam int AW  = 48;
  localparam int TW  = 4;
  localparam int RAW = $clog2(NW) + 5;
  localparam int WW  = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dec_valid = 1'b0;
  logic [AW-1:0] dec_addr = '0;
  logic dv_o, hit_o;
  logic [WW-1:0] win_o;
  logic [TW-1:0] tgt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic [31:0] m_tg [NW];
  logic [31:0] m_gl;

  always #4 clk = ~clk;

  io_win_decoder #(.NUM_WIN(NW), .ADDR_W(AW), .TGT_W(TW)) u_io_win_decoder (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dec_valid_i(dec_valid),
    .dec_addr_i(dec_addr), .dec_valid_o(dv_o), .dec_hit_o(hit_o),
    .dec_win_o(win_o), .dec_target_o(tgt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    reg_addr = RAW'(ofs); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RAW'(ofs);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] bnd(input logic [27:0] f, input logic en, input logic [2:0] junk);
    return {f, junk, en};
  endfunction

  task automatic setw(input int w, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] tg);
    wr(16*w, lo); m_lo[w] = lo;
    wr(16*w + 8, hi); m_hi[w] = hi;
    wr(16*w + 12, tg); m_tg[w] = tg;
  endtask

  // expected decode from the requirement text (R5, R6, R7, R9)
  task automatic model(input logic [AW-1:0] a, output logic h, output logic [WW-1:0] wi, output logic [TW-1:0] t);
    h = 1'b0; wi = '0; t = m_gl[TW-1:0];
    for (int i = 0; i < NW; i++) begin
      if (!h && m_lo[i][0] && a[47:20] >= m_lo[i][31:4] && a[47:20] <= m_hi[i][31:4]) begin
        h = 1'b1; wi = WW'(i); t = m_tg[i][TW-1:0];
      end
    end
  endtask

  task automatic dec(input logic [AW-1:0] a, input string req);
    logic h; logic [WW-1:0] wi; logic [TW-1:0] t;
    model(a, h, wi, t);
    @(negedge clk);
    dec_valid = 1'b1; dec_addr = a;
    @(negedge clk);
    dec_valid = 1'b0;
    chk({req, " R8 valid"}, 64'(dv_o), 64'd1);
    chk({req, " hit"}, 64'(hit_o), 64'(h));
    chk({req, " win"}, 64'(win_o), 64'(wi));
    chk({req, " target"}, 64'(tgt_o), 64'(t));
  endtask

  task automatic sweep(input string req);
    for (int f = 0; f < 32; f++)
      dec({28'(f), 20'(f * 32'h3b5c7 + 32'h1d)}, req);
    for (int f = 0; f < 4; f++)
      dec({28'hFFFFFFF - 28'(f), 20'(f * 32'h9e37)}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NW; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_tg[i] = '0; end
    m_gl = '0;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 dv", 64'(dv_o), 64'd0);
    chk("R3 hit", 64'(hit_o), 64'd0);
    chk("R3 tgt", 64'(tgt_o), 64'd0);
    rst_n = 1'b1;
    for (int o = 0; o < 16*NW + 16; o += 4) begin
      rd(o, d); chk("R3 reg reset", 64'(d), 64'd0);
    end
    dec(48'h0000_0123_4567, "R3 R7 miss after reset");

    // R1 R2 readback
    for (int w = 0; w < NW; w++)
      setw(w, 32'hA5A5_0000 ^ (w * 32'h1111_1110), 32'h5A5A_FFFE ^ (w * 32'h0101_0101), 32'hDEAD_BEE0 | w);
    wr(16*NW, 32'h1234_56A7); m_gl = 32'h1234_56A7;
    for (int w = 0; w < NW; w++) begin
      rd(16*w, d);      chk("R1 lo", 64'(d), 64'(m_lo[w]));
      rd(16*w + 8, d);  chk("R1 hi", 64'(d), 64'(m_hi[w]));
      rd(16*w + 12, d); chk("R1 tgt", 64'(d), 64'(m_tg[w]));
    end
    rd(16*NW, d); chk("R2 glob", 64'(d), 64'(m_gl));
    // R2 unmapped writes have no effect and read 0
    for (int w = 0; w < NW; w++) wr(16*w + 4, 32'hFFFF_FFFF);
    for (int o = 16*NW + 4; o < (1 << RAW); o += 4) wr(o, 32'hFFFF_FFFF);
    for (int w = 0; w < NW; w++) begin
      rd(16*w + 4, d);  chk("R2 hole reads 0", 64'(d), 64'd0);
      rd(16*w, d);      chk("R2 lo intact", 64'(d), 64'(m_lo[w]));
      rd(16*w + 8, d);  chk("R2 hi intact", 64'(d), 64'(m_hi[w]));
      rd(16*w + 12, d); chk("R2 tgt intact", 64'(d), 64'(m_tg[w]));
    end
    rd(16*NW, d); chk("R2 glob intact", 64'(d), 64'(m_gl));
    rd(16*NW + 4, d); chk("R2 beyond reads 0", 64'(d), 64'd0);

    // layout A: R4 disabled w0, R6 overlap w1/w2, R9 upper target bits, R5 top field
    setw(0, bnd(28'd0, 1'b0, 3'b000), bnd(28'd31, 1'b0, 3'b111), 32'h1);
    setw(1, bnd(28'd4, 1'b1, 3'b101), bnd(28'd9, 1'b0, 3'b010), 32'hF5);
    setw(2, bnd(28'd8, 1'b1, 3'b000), bnd(28'd12, 1'b0, 3'b000), 32'h0000_0009);
    setw(3, bnd(28'hFFFFFFE, 1'b1, 3'b000), bnd(28'hFFFFFFF, 1'b0, 3'b000), 32'h3E);
    wr(16*NW, 32'hA7); m_gl = 32'hA7;
    sweep("R4 R5 R6 R7 R9 R10 layoutA");
    // R10 same field, different low bits
    dec(48'h0000_0060_0000, "R10 low zero");
    dec(48'h0000_006F_FFFF, "R10 low ones");

    // layout B: w0 enabled over everything wins (R6)
    m_lo[0] = bnd(28'd0, 1'b1, 3'b000);
    wr(0, m_lo[0]);
    sweep("R6 layoutB");
    // R1 read-modify-write clears only enable
    rd(0, d); wr(0, d & ~32'h1); m_lo[0] = d & ~32'h1;
    rd(0, d); chk("R1 rmw", 64'(d), 64'(m_lo[0]));
    // single-field window at the same lower/upper bound (R5)
    setw(2, bnd(28'd17, 1'b1, 3'b000), bnd(28'd17, 1'b0, 3'b000), 32'h6);
    sweep("R4 R5 R7 layoutC");

    // R8 outputs hold while valid is low
    dec(48'h0000_0050_0000, "R8 base");
    @(negedge clk); dec_addr = 48'h0000_0000_0000;
    @(negedge clk);
    chk("R8 dv low", 64'(dv_o), 64'd0);
    chk("R8 hold hit", 64'(hit_o), 64'd1);
    chk("R8 hold win", 64'(win_o), 64'd1);
    chk("R8 hold tgt", 64'(tgt_o), 64'h5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule